// File: doc/BRIEF.md
# Two-Level Paged Address Translator

The block turns a 32-bit linear address into a 32-bit physical address using 4 KB pages. The mapping tables sit in ordinary memory. A requester presents one linear address together with a write flag. The block then reads a directory entry and a table entry through a single read port, one read at a time. It returns either the physical address or a page fault. The requester must wait for that response before it may present the next address.

Two control inputs say whether protected operation and paging are switched on. The block samples them at the moment a request is accepted:

- When both are set, it performs the table walk.
- Otherwise it hands back the linear address unchanged on the next cycle.

A base input gives the location of the directory. An output register keeps the linear address of the most recent fault for software to inspect.

Top module: `pgx_xlate_top`

## Requirements
- R1: When prot_en and paging_en are not both 1 in the acceptance cycle, rsp_valid rises on the next cycle with rsp_fault=0 and rsp_paddr equal to the accepted linear address, and no memory read is issued.
- R2: With translation active, the first read goes to {dir_base[31:12], laddr[31:22], 2'b00}.
- R3: When the directory entry passes its checks, the second read goes to {directory entry[31:12], laddr[21:12], 2'b00}.
- R4: A successful walk returns rsp_paddr = {table entry[31:12], laddr[11:0]} with rsp_fault=0.
- R5: Entry bit 0 is the present flag. If it is 0 in the directory entry, the walk faults after one read. If it is 0 in the table entry, the walk faults after two reads.
- R6: Entry bit 1 is the writable flag. A write request faults if that flag is 0 at either level. A read request ignores the flag.
- R7: On every fault, fault_addr takes the faulting linear address and presents it together with the response. fault_addr does not change on a successful or bypassed translation.
- R8: req_ready falls in the cycle after acceptance. It stays low until rsp_valid has been high for exactly one cycle, and it is high again in the cycle that follows.
- R9: mem_rd_en is asserted only while a walk is in progress. At most one read is outstanding. mem_rd_addr holds steady until mem_rd_valid arrives.
- R10: After reset, req_ready=1, rsp_valid=0, mem_rd_en=0 and fault_addr=0.
- R11: Clearing prot_en or paging_en during a walk has no effect on that walk. It completes with the translated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protected operation active |
| paging_en | input | 1 | Paging switched on |
| dir_base | input | 32 | Directory location; bits 31:12 used |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Physical address (meaningful when rsp_fault=0) |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_rd_en | output | 1 | Table read requested |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 32 | Returned table entry |

## Verification
Two events can fall in the same cycle: a change of the mode inputs and a walk that is already in flight.

- The bench accepts a translated request and clears both mode inputs on the very next cycle, while the directory read is still pending.
- It then expects two reads and the full translated address. It does not accept a pass-through result.

A fault and the update of the fault register also coincide: the register must already hold the new linear address in the same cycle as the fault response. The bench checks this on directed faults at both levels and on random walks with random read latencies.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   typedef enum logic [2:0] {
      PX_IDLE  = 3'd0,
      PX_DIR   = 3'd1,
      PX_TBL   = 3'd2,
      PX_DONE  = 3'd3,
      PX_FAULT = 3'd4
   } pgx_state_e;

   // flag positions inside a table entry
   localparam int unsigned PGX_PRESENT_BIT  = 0;
   localparam int unsigned PGX_WRITABLE_BIT = 1;

endpackage

// File: rtl/pgx_entry_check.sv
module pgx_entry_check #(
   parameter int unsigned ENTRY_W     = 32,
   parameter int unsigned FRAME_LSB   = 12,
   parameter bit          CHECK_WRITE = 1'b1
) (
   input  logic [ENTRY_W-1:0]           entry,
   input  logic                         is_write,
   output logic                         entry_ok,
   output logic [ENTRY_W-FRAME_LSB-1:0] frame
);
   import pgx_pkg::*;

   logic present;
   assign present = entry[PGX_PRESENT_BIT];
   assign frame   = entry[ENTRY_W-1:FRAME_LSB];

   generate
      if (CHECK_WRITE) begin : g_wr_check
         assign entry_ok = present & (entry[PGX_WRITABLE_BIT] | ~is_write);
      end else begin : g_no_wr_check
         logic unused_wr;
         assign unused_wr = is_write;
         assign entry_ok  = present;
      end
   endgenerate

endmodule

// File: rtl/pgx_addr_mux.sv
module pgx_addr_mux #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned OFS_BITS  = 2
) (
   input  logic                        sel_table,
   input  logic [ADDR_W-1:0]           dir_base,
   input  logic [ADDR_W-PAGE_BITS-1:0] dir_frame,
   input  logic [ADDR_W-1:0]           laddr,
   output logic [ADDR_W-1:0]           rd_addr
);
   localparam int unsigned HI_IDX_MSB = ADDR_W - 1;
   localparam int unsigned LO_IDX_MSB = PAGE_BITS + IDX_W - 1;

   logic [ADDR_W-1:0] dir_addr;
   logic [ADDR_W-1:0] tbl_addr;

   assign dir_addr = {dir_base[ADDR_W-1:PAGE_BITS], laddr[HI_IDX_MSB -: IDX_W],
                      {OFS_BITS{1'b0}}};
   assign tbl_addr = {dir_frame, laddr[LO_IDX_MSB -: IDX_W], {OFS_BITS{1'b0}}};
   assign rd_addr  = sel_table ? tbl_addr : dir_addr;

endmodule

// File: rtl/pgx_walk_fsm.sv
module pgx_walk_fsm #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        xlate_on,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_laddr,
   input  logic                        req_write,
   input  logic                        rd_valid,
   input  logic                        entry_ok,
   input  logic [ADDR_W-PAGE_BITS-1:0] entry_frame,
   output pgx_pkg::pgx_state_e         state,
   output logic [ADDR_W-1:0]           laddr_q,
   output logic                        write_q,
   output logic [ADDR_W-PAGE_BITS-1:0] dir_frame_q,
   output logic [ADDR_W-1:0]           paddr_q,
   output logic                        fault_set
);
   import pgx_pkg::*;

   localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;

   pgx_state_e st_q;
   logic       walking;

   assign state     = st_q;
   assign walking   = (st_q == PX_DIR) || (st_q == PX_TBL);
   assign fault_set = walking && rd_valid && !entry_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= PX_IDLE;
         laddr_q     <= '0;
         write_q     <= 1'b0;
         dir_frame_q <= '0;
         paddr_q     <= '0;
      end else begin
         unique case (st_q)
            PX_IDLE: begin
               if (req_valid) begin
                  laddr_q <= req_laddr;
                  write_q <= req_write;
                  if (xlate_on) begin
                     st_q <= PX_DIR;
                  end else begin
                     paddr_q <= req_laddr;
                     st_q    <= PX_DONE;
                  end
               end
            end
            PX_DIR: begin
               if (rd_valid) begin
                  if (!entry_ok) begin
                     st_q <= PX_FAULT;
                  end else begin
                     dir_frame_q <= entry_frame;
                     st_q        <= PX_TBL;
                  end
               end
            end
            PX_TBL: begin
               if (rd_valid) begin
                  if (!entry_ok) begin
                     st_q <= PX_FAULT;
                  end else begin
                     paddr_q <= {entry_frame[FRAME_W-1:0], laddr_q[PAGE_BITS-1:0]};
                     st_q    <= PX_DONE;
                  end
               end
            end
            default: st_q <= PX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pgx_fault_reg.sv
module pgx_fault_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] laddr,
   output logic [ADDR_W-1:0] fault_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n)       fault_addr <= '0;
      else if (capture) fault_addr <= laddr;
   end
endmodule

// File: rtl/pgx_xlate_top.sv
module pgx_xlate_top #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter bit          CHECK_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en,
   input  logic              paging_en,
   input  logic [ADDR_W-1:0] dir_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [ADDR_W-1:0] fault_addr,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [ADDR_W-1:0] mem_rd_data
);
   import pgx_pkg::*;

   localparam int unsigned OFS_BITS = $clog2(ENTRY_BYTES);
   localparam int unsigned FRAME_W  = ADDR_W - PAGE_BITS;

   initial begin
      assert (ADDR_W == PAGE_BITS + 2 * IDX_W)
         else $error("address width must split into two indices and an offset");
      assert (PAGE_BITS == IDX_W + OFS_BITS)
         else $error("one table must fill exactly one page");
   end

   pgx_state_e        state;
   logic [ADDR_W-1:0] laddr_q;
   logic              write_q;
   logic [FRAME_W-1:0] dir_frame_q;
   logic [FRAME_W-1:0] entry_frame;
   logic              entry_ok;
   logic              fault_set;
   logic              accept;

   assign req_ready = (state == PX_IDLE);
   assign accept    = req_valid && req_ready;
   assign mem_rd_en = (state == PX_DIR) || (state == PX_TBL);
   assign rsp_valid = (state == PX_DONE) || (state == PX_FAULT);
   assign rsp_fault = (state == PX_FAULT);

   pgx_walk_fsm #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .xlate_on    (prot_en && paging_en),
      .req_valid   (accept),
      .req_laddr   (req_laddr),
      .req_write   (req_write),
      .rd_valid    (mem_rd_valid),
      .entry_ok    (entry_ok),
      .entry_frame (entry_frame),
      .state       (state),
      .laddr_q     (laddr_q),
      .write_q     (write_q),
      .dir_frame_q (dir_frame_q),
      .paddr_q     (rsp_paddr),
      .fault_set   (fault_set)
   );

   pgx_entry_check #(.ENTRY_W(ADDR_W), .FRAME_LSB(PAGE_BITS),
                     .CHECK_WRITE(CHECK_WRITE)) u_chk_entry (
      .entry    (mem_rd_data),
      .is_write (write_q),
      .entry_ok (entry_ok),
      .frame    (entry_frame)
   );

   pgx_addr_mux #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
                  .OFS_BITS(OFS_BITS)) u_amux (
      .sel_table (state == PX_TBL),
      .dir_base  (dir_base),
      .dir_frame (dir_frame_q),
      .laddr     (laddr_q),
      .rd_addr   (mem_rd_addr)
   );

   pgx_fault_reg #(.ADDR_W(ADDR_W)) u_freg (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (fault_set),
      .laddr      (laddr_q),
      .fault_addr (fault_addr)
   );

endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prot_en,
   input logic              paging_en,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_laddr,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [ADDR_W-1:0] fault_addr,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_valid
);
   logic [ADDR_W-1:0] acc_la;

   always_ff @(posedge clk) begin
      if (!rst_n)                      acc_la <= '0;
      else if (req_valid && req_ready) acc_la <= req_laddr;
   end

   assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(prot_en && paging_en)) |=>
         (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr) && !mem_rd_en));

   assert_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> rsp_paddr[PAGE_BITS-1:0] == acc_la[PAGE_BITS-1:0]);

   assert_fault_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> fault_addr == acc_la);

   assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> $stable(fault_addr));

   assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

   assert_no_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en);

endmodule

bind pgx_xlate_top pgx_xlate_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .prot_en      (prot_en),
   .paging_en    (paging_en),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_laddr    (req_laddr),
   .rsp_valid    (rsp_valid),
   .rsp_fault    (rsp_fault),
   .rsp_paddr    (rsp_paddr),
   .fault_addr   (fault_addr),
   .mem_rd_en    (mem_rd_en),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rd_valid (mem_rd_valid)
);

// File: tb/sim_pgx_xlate_top.sv
`timescale 1ns/1ps
module sim_pgx_xlate_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_en = 1'b0;
   logic        paging_en = 1'b0;
   logic [31:0] dir_base = 32'h0040_3000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [31:0] rsp_paddr;
   logic [31:0] fault_addr;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;

   always #2 clk = ~clk;

   pgx_xlate_top u0 (.*);

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          finished = 1'b0;

   // responder state and knobs
   int          rd_idx = 0;
   logic [31:0] rd_log [0:3];
   bit          force_en = 1'b0;
   logic [1:0]  f_dir = 2'b11;
   logic [1:0]  f_tbl = 2'b11;
   logic [31:0] last_fault = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a, input int lvl);
      logic [31:0] h;
      logic [1:0]  fl;
      h  = (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A17_C3E5;
      fl = {|h[6:5], |h[4:2]};
      if (force_en) fl = (lvl == 0) ? f_dir : f_tbl;
      return {h[31:12], 10'b0, fl};
   endfunction

   initial begin : responder
      bit          waiting = 1'b0;
      int          left = 0;
      logic [31:0] held = '0;
      forever begin
         @(negedge clk);
         if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
         end else if (mem_rd_en) begin
            if (!waiting) begin
               waiting = 1'b1;
               left    = $urandom % 4;
               held    = mem_rd_addr;
               if (rd_idx < 4) rd_log[rd_idx] = mem_rd_addr;
            end else begin
               chk(mem_rd_addr == held, "R9 read address held", mem_rd_addr, held);
            end
            if (left == 0) begin
               mem_rd_data  = mem_word(mem_rd_addr, rd_idx);
               mem_rd_valid = 1'b1;
               rd_idx++;
               waiting = 1'b0;
            end else begin
               left--;
            end
         end
      end
   end

   task automatic xlate(input logic [31:0] la, input bit wr, input bit p, input bit g,
                        input bit drop);
      bit          e_fault;
      logic [31:0] e_pa, e_a0, e_a1, de, te;
      int          e_reads, cyc;
      bit          on;
      on = p && g;
      e_fault = 1'b0; e_a0 = '0; e_a1 = '0; e_reads = 0; e_pa = la;
      if (on) begin
         e_a0 = {dir_base[31:12], la[31:22], 2'b00};
         de = mem_word(e_a0, 0);
         e_reads = 1;
         if (!de[0] || (wr && !de[1])) e_fault = 1'b1;
         else begin
            e_a1 = {de[31:12], la[21:12], 2'b00};
            te = mem_word(e_a1, 1);
            e_reads = 2;
            if (!te[0] || (wr && !te[1])) e_fault = 1'b1;
            else e_pa = {te[31:12], la[11:0]};
         end
      end
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready when idle", {31'b0, req_ready}, 32'd1);
      rd_idx = 0;
      req_laddr = la; req_write = wr; prot_en = p; paging_en = g; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (drop) begin prot_en = 1'b0; paging_en = 1'b0; end
      cyc = 0;
      while (!rsp_valid && cyc < 100) begin
         if (req_ready) chk(1'b0, "R8 ready low during walk", 32'd1, 32'd0);
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid == 1'b1, "R8 response arrives", {31'b0, rsp_valid}, 32'd1);
      if (!on) begin
         chk(cyc == 0, "R1 bypass latency", cyc, 0);
         chk(rsp_paddr == la && !rsp_fault, "R1 bypass address", rsp_paddr, la);
      end
      chk(rsp_fault == e_fault, wr ? "R6 fault on write" : "R5 fault flag",
          {31'b0, rsp_fault}, {31'b0, e_fault});
      chk(rd_idx == e_reads, "R5 read count", rd_idx, e_reads);
      if (e_reads > 0) chk(rd_log[0] == e_a0, "R2 directory address", rd_log[0], e_a0);
      if (e_reads > 1) chk(rd_log[1] == e_a1, "R3 table address", rd_log[1], e_a1);
      if (!e_fault) chk(rsp_paddr == e_pa, drop ? "R11 translated despite mode drop"
                                                : "R4 physical address", rsp_paddr, e_pa);
      if (e_fault) last_fault = la;
      chk(fault_addr == last_fault, "R7 fault register", fault_addr, last_fault);
      chk(req_ready == 1'b0, "R8 ready low with response", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R8 single-cycle response",
          {30'b0, rsp_valid, req_ready}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h0000_5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_rd_en && fault_addr == 0, "R10 reset state",
          {req_ready, rsp_valid, mem_rd_en, fault_addr[28:0]}, 32'h8000_0000);

      // R1 pass-through in both non-translating mode combinations
      xlate(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b0);
      xlate(32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0);
      force_en = 1'b1;
      // R4 full walk, write allowed
      f_dir = 2'b11; f_tbl = 2'b11; xlate(32'h8765_4ABC, 1'b1, 1'b1, 1'b1, 1'b0);
      // R5 directory not present / table not present
      f_dir = 2'b10; xlate(32'hA000_1111, 1'b0, 1'b1, 1'b1, 1'b0);
      f_dir = 2'b11; f_tbl = 2'b10; xlate(32'hB000_2222, 1'b0, 1'b1, 1'b1, 1'b0);
      // R6 read-only directory: write faults, read passes
      f_dir = 2'b01; f_tbl = 2'b11; xlate(32'hC0DE_0333, 1'b1, 1'b1, 1'b1, 1'b0);
      xlate(32'hC0DE_0444, 1'b0, 1'b1, 1'b1, 1'b0);
      // R6 read-only table entry
      f_dir = 2'b11; f_tbl = 2'b01; xlate(32'hF00D_0555, 1'b1, 1'b1, 1'b1, 1'b0);
      // R7 successful walk and bypass leave the fault register alone
      f_tbl = 2'b11; xlate(32'h0000_0FFF, 1'b0, 1'b1, 1'b1, 1'b0);
      xlate(32'hFFFF_F000, 1'b0, 1'b0, 1'b0, 1'b0);
      // R11 mode cleared while the walk is in flight
      xlate(32'h3456_789A, 1'b0, 1'b1, 1'b1, 1'b1);
      force_en = 1'b0;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] la;
         bit p, g;
         la = $urandom;
         p  = ($urandom % 8) != 0;
         g  = ($urandom % 8) != 0;
         if (i % 50 == 0) dir_base = $urandom;
         xlate(la, 1'($urandom), p, g, 1'(($urandom % 16) == 0));
      end
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule